// File: doc/BRIEF.md
# Banded Framebuffer Page Streamer

This block moves one 16-row band of a monochrome frame from a local pixel buffer into a serial LCD controller. The band is 128 columns wide and each buffer byte carries eight vertically stacked pixels, so one band occupies 256 buffer bytes. The controller's display memory is arranged in 8-row pages. Each band is therefore written as two page transfers: the upper half of the buffer goes to the even page and the lower half to the odd page that follows it.

For each page the block frames a short command preamble with the select line and the command/data line. The preamble resets the controller's column pointer and picks the page. The block then switches the command/data line to data and streams 128 column bytes without gaps. A settle pause follows every burst. A one-cycle done pulse ends the band. The band is chosen by a 2-bit index that is captured together with a start strobe. A start strobe is only taken while the block is idle. The buffer is read through a synchronous port with one cycle of latency. The read address is moved on ahead of need, so the serial stream never stalls.

Top module: `band_page_streamer`

## Requirements
- R1: After reset the select line `cs_n_o` is high (inactive), `sclk_o` is low and `done_o` is low.
- R2: A started band b produces exactly two select-framed transfers. The first addresses page 2*b and the second addresses page 2*b+1.
- R3: Before each page transfer, `cs_n_o` is high for at least `CS_GAP` cycles and `a0_o` is low; `cs_n_o` then falls. Next, three command bytes are sent with `a0_o` low, in this order: 0x10, 0x00, then 0xB0 OR the page number in bits [3:0]. `a0_o` never changes in the middle of a byte.
- R4: After the preamble, `a0_o` is high and 128 data bytes are sent. The first page carries buffer bytes 0..127 in ascending address order. The second page carries bytes 128..255 in the same order.
- R5: Every byte is shifted out most significant bit first. `sdo_o` changes only while `sclk_o` is low and is held through each high phase. The receiver samples on the rising edge of `sclk_o`.
- R6: Within a data burst the bytes are back-to-back. Successive rising edges of `sclk_o` are exactly 2*`HALF_CYC` cycles apart, across byte boundaries too.
- R7: After the last bit of each data burst, at least `PAUSE_CYC` cycles pass before `cs_n_o` rises. The pause comes once per burst, not once per byte.
- R8: `cs_n_o` goes high after the second page's burst and its pause. `done_o` then goes high for exactly one cycle, with `cs_n_o` high.
- R9: A start strobe is ignored whenever the block is not idle, including the cycle in which `done_o` is high. Such a strobe changes neither the band being sent nor the number of transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| band_i | input | BAND_W | Band index, captured with the start strobe |
| rd_addr_o | output | log2(2*COLS) | Buffer read address |
| rd_data_i | input | 8 | Buffer read data, valid one cycle after the address |
| cs_n_o | output | 1 | Controller select, active low |
| a0_o | output | 1 | Command (0) / data (1) select |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data, MSB first |
| done_o | output | 1 | One-cycle pulse when the band is finished |

## Verification
Two events can fall in the same cycle. First, the shifter's final half-bit of one byte coincides with the loading of the next byte. The bench judges this by timing every rising serial-clock edge inside each burst against the exact 2*HALF_CYC spacing. Second, a start strobe can arrive in the very cycle the done pulse is high. The bench raises the strobe as soon as it sees done. It then confirms that no new select framing begins and that the select line stays high. A strobe in the middle of a band is also checked: the bench compares the whole decoded byte stream against the originally requested band.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSOFF,
        ST_CMD,
        ST_DATA,
        ST_PAUSE,
        ST_DONE
    } bps_state_e;

    localparam logic [7:0] CMD_COL_HI = 8'h10;
    localparam logic [7:0] CMD_COL_LO = 8'h00;
    localparam logic [7:0] CMD_PAGE   = 8'hB0;
    localparam int         NUM_CMD    = 3;

endpackage

// File: rtl/bps_shifter.sv
module bps_shifter #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       sclk_o,
    output logic       sdo_o,
    output logic       busy_o,
    output logic       last_o
);
    localparam int CW = $clog2(HALF_CYC + 1);

    typedef struct packed {
        logic [7:0]    sh;
        logic [2:0]    bitn;
        logic          hi;
        logic [CW-1:0] cnt;
        logic          busy;
    } sh_t;

    sh_t sh_d, sh_q;
    logic half_end;

    assign half_end = (sh_q.cnt == CW'(HALF_CYC - 1));
    assign last_o   = sh_q.busy && sh_q.hi && half_end && (sh_q.bitn == 3'd0);
    assign sclk_o   = sh_q.busy && sh_q.hi;
    assign sdo_o    = sh_q.sh[7];
    assign busy_o   = sh_q.busy;

    always_comb begin
        sh_d = sh_q;
        if (sh_q.busy) begin
            if (half_end) begin
                sh_d.cnt = '0;
                if (!sh_q.hi) begin
                    sh_d.hi = 1'b1;
                end else begin
                    sh_d.hi = 1'b0;
                    if (sh_q.bitn == 3'd0) begin
                        sh_d.busy = 1'b0;
                    end else begin
                        sh_d.bitn = sh_q.bitn - 3'd1;
                        sh_d.sh   = {sh_q.sh[6:0], 1'b0};
                    end
                end
            end else begin
                sh_d.cnt = sh_q.cnt + CW'(1);
            end
        end
        if (load_i && (!sh_q.busy || last_o)) begin
            sh_d.sh   = byte_i;
            sh_d.bitn = 3'd7;
            sh_d.hi   = 1'b0;
            sh_d.cnt  = '0;
            sh_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assert_load_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!sh_q.busy || last_o));

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    assert_seamless_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && load_i) |=> (busy_o && !sclk_o));

endmodule

// File: rtl/bps_seq.sv
module bps_seq
    import bps_pkg::*;
#(
    parameter int COLS      = 128,
    parameter int BAND_W    = 2,
    parameter int PAUSE_CYC = 500,
    parameter int CS_GAP    = 4,
    localparam int ADDR_W   = $clog2(2 * COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BAND_W-1:0] band_i,
    input  logic              sh_busy_i,
    input  logic              sh_last_i,
    input  logic [7:0]        rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              load_o,
    output logic [7:0]        byte_o,
    output logic              cs_n_o,
    output logic              a0_o,
    output logic              done_o
);
    localparam int IDX_W = $clog2(COLS) + 1;
    localparam int TW    = $clog2(PAUSE_CYC + CS_GAP + 1);

    typedef struct packed {
        bps_state_e        st;
        logic [BAND_W-1:0] band;
        logic              page;
        logic [IDX_W-1:0]  idx;
        logic [TW-1:0]     tmr;
        logic [ADDR_W-1:0] addr;
        logic              cs_n;
        logic              a0;
        logic              done;
    } seq_t;

    seq_t sq_d, sq_q;
    logic ready;
    logic [7:0] page_num;

    assign ready     = !sh_busy_i || sh_last_i;
    assign page_num  = 8'({sq_q.band, sq_q.page});
    assign rd_addr_o = sq_q.addr;
    assign cs_n_o    = sq_q.cs_n;
    assign a0_o      = sq_q.a0;
    assign done_o    = sq_q.done;

    always_comb begin
        load_o = 1'b0;
        byte_o = rd_data_i;
        if (sq_q.st == ST_CMD && ready && sq_q.idx < IDX_W'(NUM_CMD)) begin
            load_o = 1'b1;
            case (sq_q.idx[1:0])
                2'd0:    byte_o = CMD_COL_HI;
                2'd1:    byte_o = CMD_COL_LO;
                default: byte_o = CMD_PAGE | page_num;
            endcase
        end else if (sq_q.st == ST_DATA && ready && sq_q.idx < IDX_W'(COLS)) begin
            load_o = 1'b1;
        end
    end

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        unique case (sq_q.st)
            ST_IDLE: begin
                sq_d.cs_n = 1'b1;
                if (start_i) begin
                    sq_d.band = band_i;
                    sq_d.page = 1'b0;
                    sq_d.tmr  = '0;
                    sq_d.a0   = 1'b0;
                    sq_d.st   = ST_CSOFF;
                end
            end
            ST_CSOFF: begin
                sq_d.tmr = sq_q.tmr + TW'(1);
                if (sq_q.tmr == TW'(CS_GAP - 1)) begin
                    sq_d.cs_n = 1'b0;
                    sq_d.idx  = '0;
                    sq_d.tmr  = '0;
                    sq_d.st   = ST_CMD;
                end
            end
            ST_CMD: begin
                if (load_o) begin
                    sq_d.idx = sq_q.idx + IDX_W'(1);
                    if (sq_q.idx == IDX_W'(NUM_CMD - 1))
                        sq_d.addr = sq_q.page ? ADDR_W'(COLS) : '0;
                end else if (ready && sq_q.idx == IDX_W'(NUM_CMD)) begin
                    sq_d.a0  = 1'b1;
                    sq_d.idx = '0;
                    sq_d.st  = ST_DATA;
                end
            end
            ST_DATA: begin
                if (load_o) begin
                    sq_d.idx  = sq_q.idx + IDX_W'(1);
                    sq_d.addr = sq_q.addr + ADDR_W'(1);
                end else if (ready && sq_q.idx == IDX_W'(COLS)) begin
                    sq_d.tmr = '0;
                    sq_d.st  = ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                sq_d.tmr = sq_q.tmr + TW'(1);
                if (sq_q.tmr == TW'(PAUSE_CYC - 1)) begin
                    sq_d.cs_n = 1'b1;
                    sq_d.a0   = 1'b0;
                    sq_d.tmr  = '0;
                    if (!sq_q.page) begin
                        sq_d.page = 1'b1;
                        sq_d.st   = ST_CSOFF;
                    end else begin
                        sq_d.done = 1'b1;
                        sq_d.st   = ST_DONE;
                    end
                end
            end
            ST_DONE: sq_d.st = ST_IDLE;
            default: sq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q      <= '0;
            sq_q.st   <= ST_IDLE;
            sq_q.cs_n <= 1'b1;
        end else begin
            sq_q <= sq_d;
        end
    end

    assert_done_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_n_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sq_q.st != ST_IDLE) |=> $stable(sq_q.band));

    assert_cs_framing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy_i |-> !cs_n_o);

    assert_a0_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy_i && !sh_last_i) |=> $stable(a0_o));

endmodule

// File: rtl/band_page_streamer.sv
module band_page_streamer #(
    parameter int COLS      = 128,
    parameter int BAND_W    = 2,
    parameter int HALF_CYC  = 2,
    parameter int PAUSE_CYC = 500,
    parameter int CS_GAP    = 4,
    localparam int ADDR_W   = $clog2(2 * COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BAND_W-1:0] band_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              cs_n_o,
    output logic              a0_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              done_o
);
    logic       load;
    logic [7:0] load_byte;
    logic       sh_busy;
    logic       sh_last;

    bps_seq #(
        .COLS      (COLS),
        .BAND_W    (BAND_W),
        .PAUSE_CYC (PAUSE_CYC),
        .CS_GAP    (CS_GAP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .band_i    (band_i),
        .sh_busy_i (sh_busy),
        .sh_last_i (sh_last),
        .rd_data_i (rd_data_i),
        .rd_addr_o (rd_addr_o),
        .load_o    (load),
        .byte_o    (load_byte),
        .cs_n_o    (cs_n_o),
        .a0_o      (a0_o),
        .done_o    (done_o)
    );

    bps_shifter #(
        .HALF_CYC (HALF_CYC)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .byte_i (load_byte),
        .sclk_o (sclk_o),
        .sdo_o  (sdo_o),
        .busy_o (sh_busy),
        .last_o (sh_last)
    );

    assert_idle_clock_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

endmodule

// File: tb/band_page_streamer_bench.sv
module band_page_streamer_bench;
    localparam int CLK_P  = 10;
    localparam int COLS   = 128;
    localparam int HALF   = 2;
    localparam int PAUSE  = 500;
    localparam int GAP    = 4;
    localparam int NBYTES = 2 * (3 + COLS);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] band = 2'd0;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       cs_n, a0, sclk, sdo, done;

    logic [7:0] mem [0:255];

    always #(CLK_P / 2) clk = ~clk;
    always_ff @(posedge clk) rd_data <= mem[rd_addr];

    band_page_streamer #(
        .COLS(COLS), .BAND_W(2), .HALF_CYC(HALF), .PAUSE_CYC(PAUSE), .CS_GAP(GAP)
    ) u_band_page_streamer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .band_i(band),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data), .cs_n_o(cs_n), .a0_o(a0),
        .sclk_o(sclk), .sdo_o(sdo), .done_o(done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // receiver model, sampled on the falling clock edge
    logic [7:0] rx_byte [0:NBYTES+15];
    logic       rx_a0   [0:NBYTES+15];
    int  rx_n = 0, seg = 0, bitn = 0, done_cnt = 0;
    int  stab_err = 0, gap_err = 0, pause_err = 0, a0_err = 0, csgap_err = 0;
    int  done_err = 0;
    int  cyc = 0, last_rise = 0, cs_rise_cyc = 0;
    bit  rise_ok = 1'b0, burst_end_ok = 1'b0;
    logic [7:0] sr = 8'h00;
    logic byte_a0 = 1'b0;
    logic p_sclk = 1'b0, p_sdo = 1'b0, p_cs = 1'b1, p_done = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_cs && !cs_n) begin
                seg++;
                bitn = 0;
                rise_ok = 1'b0;
                if (cyc - cs_rise_cyc < GAP || a0) csgap_err++;
            end
            if (!p_cs && cs_n) begin
                cs_rise_cyc = cyc;
                if (!burst_end_ok || (cyc - last_rise) < PAUSE) pause_err++;
                burst_end_ok = 1'b0;
            end
            if (sclk && p_sclk && sdo != p_sdo) stab_err++;
            if (!cs_n && sclk && !p_sclk) begin
                if (bitn == 0) byte_a0 = a0;
                else if (a0 != byte_a0) a0_err++;
                if (a0) begin
                    if (rise_ok && (cyc - last_rise) != 2 * HALF) gap_err++;
                    rise_ok = 1'b1;
                    last_rise = cyc;
                    burst_end_ok = 1'b1;
                end
                sr = {sr[6:0], sdo};
                bitn++;
                if (bitn == 8) begin
                    if (rx_n < NBYTES + 16) begin
                        rx_byte[rx_n] = sr;
                        rx_a0[rx_n]   = byte_a0;
                    end
                    rx_n++;
                    bitn = 0;
                end
            end
            if (done) begin
                done_cnt++;
                if (p_done || !cs_n) done_err++;
            end
        end
        p_sclk = sclk; p_sdo = sdo; p_cs = cs_n; p_done = done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        rx_n = 0; seg = 0; bitn = 0; done_cnt = 0;
        stab_err = 0; gap_err = 0; pause_err = 0; a0_err = 0; csgap_err = 0;
        done_err = 0;
    endtask

    task automatic fill(input int b);
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + b * 37 + 3) ^ (i >> 3));
    endtask

    task automatic run_band(input int b, input bit intrude);
        int t;
        int pg_err, pre_err, dat_err;
        fill(b);
        clear_log();
        @(negedge clk);
        start = 1'b1; band = 2'(b);
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 40000) begin
            if (intrude && t == 300) begin
                start = 1'b1; band = 2'(b + 2);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        chk(done, "R8 done reached", t, 0);
        repeat (20) @(negedge clk);
        pg_err = 0; pre_err = 0; dat_err = 0;
        chk(seg == 2, "R2 transfer count", seg, 2);
        chk(rx_n == NBYTES, "R2 byte count", rx_n, NBYTES);
        if (rx_n == NBYTES) begin
            for (int p = 0; p < 2; p++) begin
                int base = p * (3 + COLS);
                if (rx_byte[base] != 8'h10 || rx_byte[base+1] != 8'h00 ||
                    rx_a0[base] || rx_a0[base+1] || rx_a0[base+2]) pre_err++;
                if (rx_byte[base+2] != (8'hB0 | 8'(2 * b + p))) pg_err++;
                for (int i = 0; i < COLS; i++)
                    if (rx_byte[base+3+i] != mem[p*COLS+i] || !rx_a0[base+3+i]) dat_err++;
            end
        end
        chk(pg_err == 0, "R2 page select", pg_err, 0);
        chk(pre_err == 0 && csgap_err == 0 && a0_err == 0, "R3 preamble",
            pre_err + csgap_err + a0_err, 0);
        chk(dat_err == 0, "R4 data and R5 MSB first", dat_err, 0);
        chk(stab_err == 0, "R5 data hold", stab_err, 0);
        chk(gap_err == 0, "R6 back-to-back", gap_err, 0);
        chk(pause_err == 0, "R7 pause", pause_err, 0);
        chk(done_cnt == 1 && done_err == 0, "R8 done pulse", done_cnt, 1);
        chk(cs_n, "R8 cs released", cs_n, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n at reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk at reset", sclk, 0);
        chk(done == 1'b0, "R1 done at reset", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int b = 0; b < 4; b++) run_band(b, 1'b0);
        // R9: strobe in the middle of a band
        run_band(1, 1'b1);
        // R9: strobe in the same cycle as done
        fill(2);
        clear_log();
        start = 1'b1; band = 2'd2;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        start = 1'b1; band = 2'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        chk(seg == 2, "R9 start with done ignored", seg, 2);
        chk(cs_n && !sclk, "R9 bus idle after ignored start", cs_n, 1);
        run_band(3, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule